// File: doc/BRIEF.md
# Interleaved DRAM Range Router

This block decides which memory node owns a 40-bit physical request. It holds eight programmable address windows. Each window is described by a pair of 32-bit words, a lower word and an upper word. For every request the block reports three things: whether some window claimed the request, the node that window points to, and the window's number. The routing decision is purely combinational from the request inputs and the stored words. Only the window words themselves are registered.

A window claims a request when three conditions hold. The window must be open for the access direction (read or write). The top sixteen address bits must fall between the window's lower and upper bounds. Finally, the window's node-interleave filter on address bits 14 to 12 must agree with the request. The filter lets several windows share one address span, so that consecutive 4 KiB blocks are spread over two, four or eight nodes.

Software loads the windows through a small word port that has a write strobe. The same port reads back the stored words, with unused bits returned as zero.

Top module: `dram_route_top`

## Requirements
- R1: After a synchronous active-low reset, every stored word reads as zero, and no request is claimed until a window is programmed.
- R2: `cfg_idx[3:1]` selects the window and `cfg_idx[0]` selects the word (0 = lower word, 1 = upper word). A write strobe stores `cfg_wdata` at the next clock edge. `cfg_rdata` returns the addressed stored word, with lower-word bits outside [31:16], [10:8] and [1:0] reading zero, and upper-word bits outside [31:16], [10:8] and [2:0] reading zero.
- R3: A window's span test passes when lower[31:16] <= addr[39:24] <= upper[31:16], inclusive at both ends.
- R4: A read can only be claimed by a window whose lower word bit [0] is set. A write can only be claimed by a window whose lower word bit [1] is set.
- R5: On a claim, `route_node` equals bits [2:0] of the claiming window's upper word.
- R6: Lower word bits [10:8] are an interleave mask and upper word bits [10:8] are a select value. The filter passes when every address bit in [14:12] that the mask enables equals the matching select bit. A mask of zero always passes.
- R7: When several windows pass, the lowest-numbered one claims the request, and `route_pair` gives its number.
- R8: When no window passes, `route_hit` is 0 and both `route_node` and `route_pair` are 0.
- R9: A write changes only the addressed word. All other stored words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Window word write strobe |
| cfg_idx | input | 4 | Window number [3:1] and word select [0] |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Addressed stored word |
| req_addr | input | 40 | Physical request address |
| req_is_wr | input | 1 | 1 = write request, 0 = read request |
| route_hit | output | 1 | Some window claimed the request |
| route_node | output | 3 | Destination node of the claiming window |
| route_pair | output | 3 | Number of the claiming window |

## Verification
The assertions check four properties on every cycle. A claim always comes from a passing window and never from a higher-numbered one while a lower one passes. A miss drives zeros on the node and window outputs. A claimed request always has the matching direction enable set. Stored words change only under a write, and a write lands in the addressed word with its kept bits. Only the bench scenarios can show the rest: the actual span bounds at both edges, the correct interleave agreement for every mask and select combination, and the node values delivered. Those checks sweep the top address bits near every programmed edge, across all eight interleave patterns and both directions, against an arithmetic model.

// File: rtl/dram_route_pkg.sv
// Shared constants, the decoded window view and the word decoder used by the
// router. Assumes the fixed 32-bit window word layout described in the brief.
package dram_route_pkg;

    localparam int ADDR_W   = 40;
    localparam int WORD_W   = 32;
    localparam int SPAN_W   = 16;
    localparam int SPAN_LO  = ADDR_W - SPAN_W;   // address bit 24
    localparam int NODE_W   = 3;
    localparam int ILV_W    = 3;
    localparam int ILV_LO   = 12;

    // Bits kept in the lower and upper window words; the rest read as zero.
    localparam logic [WORD_W-1:0] LOWER_KEEP = 32'hFFFF_0703;
    localparam logic [WORD_W-1:0] UPPER_KEEP = 32'hFFFF_0707;

    typedef struct packed {
        logic [SPAN_W-1:0] span_lo;
        logic [SPAN_W-1:0] span_hi;
        logic              rd_open;
        logic              wr_open;
        logic [ILV_W-1:0]  ilv_mask;
        logic [ILV_W-1:0]  ilv_sel;
        logic [NODE_W-1:0] node;
    } win_cfg_t;

    // Turns a stored lower/upper word pair into named fields.
    function automatic win_cfg_t unpack_window(input logic [WORD_W-1:0] lower,
                                               input logic [WORD_W-1:0] upper);
        win_cfg_t w;
        w.span_lo  = lower[31:16];
        w.span_hi  = upper[31:16];
        w.rd_open  = lower[0];
        w.wr_open  = lower[1];
        w.ilv_mask = lower[10:8];
        w.ilv_sel  = upper[10:8];
        w.node     = upper[2:0];
        return w;
    endfunction

endpackage

// File: rtl/dram_win_store.sv
// Window word storage: two words per window, written through a strobe and
// read back combinationally. Assumes NUM_WIN is a power of two.
module dram_win_store
    import dram_route_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN),
    localparam int IDX_W  = WIN_W + 1,
    localparam int NWORDS = 2 * NUM_WIN
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W-1:0]           rdata,
    output win_cfg_t [NUM_WIN-1:0]      cfg
);

    logic [NWORDS-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]             keep_now;

    // Select the kept-bit mask for the addressed word type.
    always_comb begin
        keep_now = idx[0] ? UPPER_KEEP : LOWER_KEEP;
    end

    // Hold the window words; clear on reset, update the addressed word on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (we) begin
            words[idx] <= wdata & keep_now;
        end
    end

    // Return the addressed word for software reads.
    always_comb begin
        rdata = words[idx];
    end

    // Present every window in decoded form to the compare logic.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_unpack
        always_comb begin
            cfg[g] = unpack_window(words[2*g], words[2*g+1]);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> words == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words));

    // R2
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> words[$past(idx)] == ($past(wdata) & $past(keep_now)));

endmodule

// File: rtl/dram_win_match.sv
// Tests one window against the request: direction permission, inclusive span
// on the top address bits and the interleave filter on bits 14..12.
module dram_win_match
    import dram_route_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_wr,
    output logic              pass
);

    logic [SPAN_W-1:0] top_bits;
    logic [ILV_W-1:0]  ilv_bits;
    logic              dir_ok;
    logic              span_ok;
    logic              ilv_ok;

    // Split the request into the fields each test needs.
    always_comb begin
        top_bits = addr[ADDR_W-1:SPAN_LO];
        ilv_bits = addr[ILV_LO +: ILV_W];
    end

    // Evaluate the three independent tests and combine them.
    always_comb begin
        dir_ok  = is_wr ? cfg.wr_open : cfg.rd_open;
        span_ok = (top_bits >= cfg.span_lo) && (top_bits <= cfg.span_hi);
        ilv_ok  = ((ilv_bits ^ cfg.ilv_sel) & cfg.ilv_mask) == '0;
        pass    = dir_ok && span_ok && ilv_ok;
    end

endmodule

// File: rtl/dram_win_pick.sv
// Fixed-priority pick among passing windows: the lowest number wins. Outputs
// are forced to zero when nothing passes.
module dram_win_pick
    import dram_route_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WIN-1:0]     pass_vec,
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    output logic                   hit,
    output logic [NODE_W-1:0]      node,
    output logic [WIN_W-1:0]       win
);

    // Scan from the top so the lowest passing window is the last to assign.
    always_comb begin
        hit  = 1'b0;
        node = '0;
        win  = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (pass_vec[i]) begin
                hit  = 1'b1;
                node = cfg[i].node;
                win  = WIN_W'(i);
            end
        end
    end

    // R7
    win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pass_vec[win] &&
                 ((pass_vec & ((NUM_WIN'(1) << win) - NUM_WIN'(1))) == '0)));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_vec == '0) |-> (!hit && node == '0 && win == '0));

    // R5
    node_from_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> node == cfg[win].node);

endmodule

// File: rtl/dram_route_top.sv
// Routes a 40-bit physical request to a node through eight programmable
// windows. Assumes the request inputs are stable around the sampling point;
// the routing path is combinational, the window words are registered.
module dram_route_top
    import dram_route_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = $clog2(NUM_WIN),
    localparam int IDX_W  = WIN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output logic [WORD_W-1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_is_wr,
    output logic                route_hit,
    output logic [NODE_W-1:0]   route_node,
    output logic [WIN_W-1:0]    route_pair
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic     [NUM_WIN-1:0] pass_vec;

    dram_win_store #(.NUM_WIN(NUM_WIN)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        dram_win_match u_match (
            .cfg   (cfg[g]),
            .addr  (req_addr),
            .is_wr (req_is_wr),
            .pass  (pass_vec[g])
        );
    end

    dram_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass_vec (pass_vec),
        .cfg      (cfg),
        .hit      (route_hit),
        .node     (route_node),
        .win      (route_pair)
    );

    // R4
    dir_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_hit |-> (req_is_wr ? cfg[route_pair].wr_open
                                 : cfg[route_pair].rd_open));

    // R3
    span_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_hit |-> (req_addr[ADDR_W-1:SPAN_LO] >= cfg[route_pair].span_lo &&
                       req_addr[ADDR_W-1:SPAN_LO] <= cfg[route_pair].span_hi));

endmodule

// File: tb/sim_dram_route_top.sv
module sim_dram_route_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [39:0] req_addr = '0;
    logic        req_is_wr = 1'b0;
    logic        route_hit;
    logic [2:0]  route_node;
    logic [2:0]  route_pair;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] mdl [16];

    always #10 clk = ~clk;   // 50 MHz

    dram_route_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .req_is_wr(req_is_wr), .route_hit(route_hit), .route_node(route_node),
        .route_pair(route_pair)
    );

    task automatic chk(input bit ok, input string tag, input logic [39:0] act,
                       input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [31:0] d);
        @(negedge clk);
        cfg_idx = 4'(i); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        mdl[i] = d & ((i % 2) ? 32'hFFFF_0707 : 32'hFFFF_0703);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            cfg_idx = 4'(i);
            #2;
            chk(cfg_rdata == mdl[i], tag, 40'(cfg_rdata), 40'(mdl[i]));
        end
    endtask

    // Model: lowest window whose direction, span and interleave tests pass.
    task automatic expect_route(input logic [39:0] a, input bit w, output bit h,
                                output logic [2:0] n, output logic [2:0] p);
        h = 0; n = 0; p = 0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] lo, up;
            bit ok;
            lo = mdl[2*i]; up = mdl[2*i+1];
            ok = (w ? lo[1] : lo[0]) && a[39:24] >= lo[31:16] &&
                 a[39:24] <= up[31:16];
            for (int b = 0; b < 3; b++)
                if (lo[8+b] && (a[12+b] != up[8+b])) ok = 0;
            if (ok && !h) begin h = 1; n = up[2:0]; p = 3'(i); end
        end
    endtask

    task automatic probe(input logic [39:0] a, input bit w, input string tag);
        bit h; logic [2:0] n, p;
        expect_route(a, w, h, n, p);
        @(negedge clk);
        req_addr = a; req_is_wr = w;
        #2;
        chk(route_hit == h, {tag, " hit R3"}, 40'(route_hit), 40'(h));
        chk(route_node == n, {tag, " node R5"}, 40'(route_node), 40'(n));
        chk(route_pair == p, {tag, " pair R7"}, 40'(route_pair), 40'(p));
    endtask

    task automatic sweep(input logic [15:0] from, input logic [15:0] to,
                         input string tag);
        for (int u = int'(from); u <= int'(to); u++)
            for (int k = 0; k < 8; k++)
                for (int w = 0; w < 2; w++)
                    probe({16'(u), 9'h0A5, 3'(k), 12'h3C1}, w[0], tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_all("R1 reset word");
        sweep(16'h0000, 16'h0003, "R1 R8 reset miss");
        sweep(16'hFFFE, 16'hFFFF, "R1 R8 reset miss");

        // R2: all-ones per word, read back masked; R9: neighbours untouched
        for (int i = 0; i < 16; i++) begin
            put(i, 32'hFFFF_FFFF);
            read_all("R2 R9 word");
            put(i, 32'h0);
        end
        read_all("R2 cleared");

        // Windows: 0 read-only 0x10..0x1F node5; 1 rd+wr 0x18..0x30 node2
        put(0, 32'h0010_0001); put(1, 32'h001F_0005);
        put(2, 32'h0018_0003); put(3, 32'h0030_0002);
        // 3 and 4 share 0x40 with 2-bit interleave (R6)
        put(6, 32'h0040_0303); put(7, 32'h0040_0206);
        put(8, 32'h0040_0303); put(9, 32'h0040_0107);
        // 5: write-only 0x41..0x44 single bit interleave sel=1
        put(10, 32'h0041_0102); put(11, 32'h0044_0104);
        // 7: full-width interleave at the top of the space
        put(14, 32'hFFFF_0703); put(15, 32'hFFFF_0501);
        read_all("R2 programmed");
        sweep(16'h0000, 16'h0050, "R3 R4 R6 R7");
        sweep(16'hFFF0, 16'hFFFF, "R3 R6 edge");

        // R4 directed: write into read-only span misses
        @(negedge clk); req_addr = {16'h0012, 24'h0}; req_is_wr = 1'b1; #2;
        chk(route_hit == 1'b0, "R4 write to read-only", 40'(route_hit), 40'd0);
        chk(route_node == 3'd0 && route_pair == 3'd0, "R8 miss zero",
            40'({route_node, route_pair}), 40'd0);
        // R6 directed: bits 14..12 = 6 picks window 3 node 6
        @(negedge clk); req_addr = {16'h0040, 9'h0, 3'd6, 12'h0}; req_is_wr = 1'b0; #2;
        chk(route_node == 3'd6 && route_pair == 3'd3, "R6 interleave pick",
            40'({route_node, route_pair}), 40'h33);

        // R1 again: reset clears programmed windows
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        read_all("R1 re-reset");
        sweep(16'h0040, 16'h0041, "R1 R8 after reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule